// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block is the host-side consumer of a small circular ring of receive descriptors. Each entry's 32-bit status word lives in a local descriptor store. A receiver, outside this block, releases an entry by writing its status word through a producer write port. The host asks the block to service the entry at the head of the ring. The block checks the ownership flag. If the receiver has released the entry, the block sorts the status word into one of three outcomes: a good frame, a fragment to throw away, or a fatal receive error.

For a good frame, the block reports the payload length with the four CRC bytes removed. It then returns the descriptor to the receiver and moves the head forward. A fragment is skipped, and the block raises a warning when the fragment looks oversized. A fatal error raises a reset request and leaves the head where it is. The host is then expected to issue an init request, which rebuilds every descriptor. A peek mode tells the host whether a frame is waiting without consuming it. A read port shows the status and length words of any entry.

Top module: `rx_ring_consumer`

## Requirements
- R1: After reset, and one cycle after an init request, `head` is 0 and every status word reads 0x80000000. Every length word reads 1536 (0x600) with bit 31 set as the completion-interrupt flag. Only the last entry also has bit 25 set as its end-of-ring flag.
- R2: A request made while bit 31 of the head status is set gives result code 1 (wait). The head and all status words stay unchanged.
- R3: A status word `s` is a good frame when `s & 0x38008300 == 0x300`. The result is code 3, and `res_len` is `s[26:16] - 4` modulo 2^11.
- R4: Consuming a good frame rewrites the head status to exactly 0x80000000 and advances `head` by one.
- R5: When `s & 0x38000300 != 0x300`, the entry is a fragment. The result is code 4, `head` advances, and the status word is left as it was. `oversize` is 1 unless `s[15:0] == 0x7FFF`.
- R6: Otherwise bit 15 is set and the entry is fatal. The result is code 5 and `reset_req` is 1. `head` and the status word stay unchanged.
- R7: A request with `peek` set on a released head gives code 2 (ready) and changes neither `head` nor any status word. On an owned head it gives code 1.
- R8: `head` advances modulo RING, which is a power of two, so it wraps from RING-1 to 0.
- R9: Every result appears in the cycle after the request. `res_valid` is then 1 for exactly that cycle. Without a request, `res_valid`, `res_code`, `res_len`, `oversize` and `reset_req` are all 0.
- R10: An init request overrides any other input in the same cycle. A producer write to the head entry in the same cycle as a consume wins over the block's own rewrite. The classification still uses the old status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Rebuild all descriptors and clear the head |
| req | input | 1 | Service the head descriptor |
| peek | input | 1 | With req: report readiness only |
| wr_en | input | 1 | Producer status write enable |
| wr_idx | input | IW | Producer write index |
| wr_status | input | 32 | Producer status word |
| rd_idx | input | IW | Descriptor read index |
| rd_status | output | 32 | Status word of entry rd_idx |
| rd_len | output | 32 | Length word of entry rd_idx |
| head | output | IW | Current head index |
| res_valid | output | 1 | Result valid pulse |
| res_code | output | 3 | 0 none, 1 wait, 2 ready, 3 good, 4 fragment, 5 fatal |
| res_len | output | 11 | Good-frame length without CRC |
| oversize | output | 1 | Fragment oversize warning |
| reset_req | output | 1 | Fatal error reset request |

## Verification
The checker assumes that `head` changes only through a consume or an init. It also assumes that an init request never shares a cycle with a result it would hide, because init clears the result registers. The stimulus keeps init requests apart from the cycles in which results are checked for head movement. It uses a status pattern for each class, including a length field below four and a fragment whose low half is exactly 0x7FFF. The stimulus also places one producer write on the head in the same cycle as a consume, to exercise the R10 priority.

// File: rtl/rx_ring_consumer.sv
module rx_ring_consumer #(
  parameter int RING = 2,
  parameter int BUF_BYTES = 1536,
  localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic          req,
  input  logic          peek,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_status,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_status,
  output logic [31:0]   rd_len,
  output logic [IW-1:0] head,
  output logic          res_valid,
  output logic [2:0]    res_code,
  output logic [10:0]   res_len,
  output logic          oversize,
  output logic          reset_req
);
  localparam logic [31:0] OWNED = 32'h8000_0000;
  localparam logic [31:0] LEN_BASE = 32'h8000_0000 | 32'(BUF_BYTES);
  localparam logic [31:0] EOR = 32'h0200_0000;

  logic [31:0] stat [RING];
  logic [31:0] hs;
  logic        is_good, is_frag;

  assign hs        = stat[head];
  assign is_good   = (hs & 32'h3800_8300) == 32'h0000_0300;
  assign is_frag   = (hs & 32'h3800_0300) != 32'h0000_0300;
  assign rd_status = stat[rd_idx];
  assign rd_len    = LEN_BASE | ((32'(rd_idx) == RING - 1) ? EOR : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n || init_req) begin
      for (int i = 0; i < RING; i++) stat[i] <= OWNED;
      head      <= '0;
      res_valid <= 1'b0;
      res_code  <= 3'd0;
      res_len   <= '0;
      oversize  <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      res_valid <= req;
      res_code  <= 3'd0;
      res_len   <= '0;
      oversize  <= 1'b0;
      reset_req <= 1'b0;
      if (req) begin
        if (hs[31]) res_code <= 3'd1;
        else if (peek) res_code <= 3'd2;
        else if (is_good) begin
          res_code   <= 3'd3;
          res_len    <= hs[26:16] - 11'd4;
          stat[head] <= OWNED;
          head       <= head + 1'b1;
        end else if (is_frag) begin
          res_code <= 3'd4;
          oversize <= hs[15:0] != 16'h7FFF;
          head     <= head + 1'b1;
        end else begin
          res_code  <= 3'd5;
          reset_req <= 1'b1;
        end
      end
      if (wr_en) stat[wr_idx] <= wr_status;
    end
  end
endmodule

module rx_ring_consumer_chk #(parameter int IW = 1) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] head,
  input logic          res_valid,
  input logic [2:0]    res_code,
  input logic          oversize,
  input logic          reset_req
);
  // R6
  fatal_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (res_valid && res_code == 3'd5));
  // R6
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 3'd5) |-> head == $past(head));
  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 3'd1) |-> head == $past(head));
  // R7
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 3'd2) |-> head == $past(head));
  // R4
  good_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 3'd3) |-> head == IW'($past(head) + 1'b1));
  // R5
  frag_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 3'd4) |-> head == IW'($past(head) + 1'b1));
  // R5
  oversize_only_frag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oversize |-> (res_valid && res_code == 3'd4));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_code == 3'd0 && !reset_req && !oversize));
endmodule

bind rx_ring_consumer rx_ring_consumer_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .head(head), .res_valid(res_valid),
  .res_code(res_code), .oversize(oversize), .reset_req(reset_req)
);

// File: tb/sim_rx_ring_consumer.sv
module sim_rx_ring_consumer;
  localparam int RING = 2;
  localparam int IW = 1;

  logic clk = 0, rst_n = 0, init_req = 0, req = 0, peek = 0, wr_en = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_status = '0;
  logic [31:0] rd_status, rd_len;
  logic [IW-1:0] head;
  logic res_valid, oversize, reset_req;
  logic [2:0] res_code;
  logic [10:0] res_len;

  rx_ring_consumer #(.RING(RING)) u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit started = 0, finished = 0;

  logic [31:0] m_st [RING];
  int m_head = 0, m_code = 0, m_len = 0;
  bit m_valid = 0, m_ovs = 0, m_rst = 0;

  always @(posedge clk) begin
    logic [31:0] s;
    int nxt, rew;
    started = 1;
    if (!rst_n || init_req) begin
      for (int i = 0; i < RING; i++) m_st[i] = 32'h8000_0000;
      m_head = 0; m_valid = 0; m_code = 0; m_len = 0; m_ovs = 0; m_rst = 0;
    end else begin
      s = m_st[m_head];
      m_valid = req; m_code = 0; m_len = 0; m_ovs = 0; m_rst = 0;
      nxt = m_head; rew = -1;
      if (req) begin
        if (s[31]) m_code = 1;
        else if (peek) m_code = 2;
        else if ((s & 32'h3800_8300) == 32'h300) begin
          m_code = 3; m_len = (int'(s[26:16]) - 4) & 32'h7FF;
          rew = m_head; nxt = (m_head + 1) % RING;
        end else if ((s & 32'h3800_0300) != 32'h300) begin
          m_code = 4; m_ovs = (s[15:0] != 16'h7FFF);
          nxt = (m_head + 1) % RING;
        end else begin
          m_code = 5; m_rst = 1;
        end
      end
      if (rew >= 0) m_st[rew] = 32'h8000_0000;
      if (wr_en) m_st[int'(wr_idx)] = wr_status;
      m_head = nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    logic [31:0] exp_len;
    exp_len = 32'h8000_0600 | ((int'(rd_idx) == RING - 1) ? 32'h0200_0000 : 32'h0);
    chk("R4/R8 head", 32'(head), 32'(m_head));
    chk("R9 res_valid", 32'(res_valid), 32'(m_valid));
    chk("R2/R3/R5/R6/R7 res_code", 32'(res_code), 32'(m_code));
    chk("R3 res_len", 32'(res_len), 32'(m_len));
    chk("R5 oversize", 32'(oversize), 32'(m_ovs));
    chk("R6 reset_req", 32'(reset_req), 32'(m_rst));
    chk("R1/R4/R10 rd_status", rd_status, m_st[int'(rd_idx)]);
    chk("R1 rd_len", rd_len, exp_len);
  end

  task automatic step(input bit rq, input bit pk, input bit we, input int wi,
                      input logic [31:0] ws, input bit ini, input int ri);
    @(posedge clk); #1;
    req = rq; peek = pk; wr_en = we; wr_idx = IW'(wi); wr_status = ws;
    init_req = ini; rd_idx = IW'(ri);
  endtask

  task automatic idle(input int ri);
    step(0, 0, 0, 0, 0, 0, ri);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(0); idle(1);                              // R1 reset state
    step(1, 0, 0, 0, 0, 0, 0);                     // R2 owned wait
    step(1, 1, 0, 0, 0, 0, 0);                     // R7 peek on owned
    step(0, 0, 1, 0, 32'h0044_0300, 0, 0);         // release entry0 good, len 64
    step(1, 1, 0, 0, 0, 0, 0);                     // R7 peek ready
    step(1, 0, 0, 0, 0, 0, 0);                     // R3/R4 consume
    idle(0);
    step(0, 0, 1, 1, 32'h05F2_0300, 0, 1);         // entry1 good len 1518
    step(1, 0, 0, 0, 0, 0, 1);                     // R8 wrap to 0
    idle(1);
    step(0, 0, 1, 0, 32'h0040_0100, 0, 0);         // fragment, oversize
    step(1, 0, 0, 0, 0, 0, 0);                     // R5
    step(0, 0, 1, 1, 32'h0800_7FFF, 0, 1);         // fragment, no oversize
    step(1, 0, 0, 0, 0, 0, 1);                     // R5 wrap
    idle(1);
    step(0, 0, 1, 0, 32'h0040_8300, 0, 0);         // fatal
    step(1, 0, 0, 0, 0, 0, 0);                     // R6
    step(1, 0, 0, 0, 0, 0, 0);                     // R6 repeats
    idle(0);
    step(0, 0, 0, 0, 0, 1, 1);                     // R1 init
    idle(0); idle(1);
    step(0, 0, 1, 0, 32'h0002_0300, 0, 0);         // R3 length below 4
    step(1, 0, 1, 1, 32'h0010_0300, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1);                     // back-to-back consume
    idle(0);
    step(0, 0, 1, 0, 32'h0100_0300, 0, 0);
    step(1, 0, 1, 0, 32'h1234_0300, 0, 0);         // R10 producer write wins
    idle(0);
    step(1, 0, 0, 0, 0, 1, 0);                     // R10 init overrides req
    idle(0); idle(1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule